// File: doc/BRIEF.md
# Load Port Address Stage with Base-Page Speculation

This block sits in front of a cache load port and decides, for every load, how many cycles it takes before its data is ready. Each request carries a base address, a displacement, two flags that describe an optional index operand, a flag telling whether the base value was produced by an earlier load, and a tag. Some loads are cheap and safe to speculate on: their base came from a previous load, their displacement is small and non-negative, and they have no live index. For these loads the translation lookup is started from the page of the base value alone, while the full address sum is still being formed. A page comparison then confirms the guess or forces a replay.

Every accepted load leaves the block exactly once, on its completion cycle. It leaves as a response pulse that carries the tag and the latency class it got: fast, normal or replay. A one-bit history remembers a failed guess and sends the next qualifying load down the normal path. This keeps a chain of loads that always crosses pages from paying the replay cost on every link.

Requests use valid/ready. A request is taken on a rising clock edge where both are high. The block lowers ready for the whole time a replay is outstanding. It also lowers ready when the completion cycle the offered request would need is already claimed by an older load. Because of this second rule, ready may depend on the fields of the offered request. A requester must hold its request stable until it is taken. The response has no back-pressure.

Top module: `ldfp_stage`

## Requirements
- R1: A load qualifies for speculation only if its signed displacement lies between 0 and 2047 inclusive. Other displacements (2048 or negative) take the normal path.
- R2: A load qualifies only if `req_base_from_load` is 1. A base produced by an ALU operation takes the normal path.
- R3: A load with `req_idx_valid`=1 qualifies only if `req_idx_zero`=1, meaning the index was set by a zeroing idiom. Any other indexed load takes the normal path.
- R4: A speculated load whose guess holds responds 4 cycles after acceptance. A normal-path load responds 5 cycles after acceptance.
- R5: A speculated load whose base and effective address (base + displacement) differ in bits 63:12, with 4 KiB pages, is replayed. It responds REPLAY_LAT cycles after acceptance, which is 10 by default and may be set to 9.
- R6: After a replay, the next qualifying load is forced to the normal path and the history is cleared, so the load after it may speculate again. Loads that do not qualify leave the history untouched. A chain that always crosses pages therefore runs at 10, 5, 10, 5 cycles, 7.5 on average.
- R7: From the cycle after a replayed load is accepted up to and including its response cycle, `req_ready` is 0.
- R8: At most one response appears per cycle. A request whose completion cycle is already taken is refused until that cycle is free.
- R9: After reset `req_ready` is 1, `resp_valid` is 0 and the history is clear.
- R10: The response carries the request's tag and a class code of 0 for fast, 1 for normal and 2 for replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_base | input | 64 | Base address value |
| req_idx_valid | input | 1 | Load has an index operand |
| req_idx_zero | input | 1 | Index was set by a zeroing idiom |
| req_disp | input | 16 | Signed displacement |
| req_base_from_load | input | 1 | Base value came from an earlier load |
| req_tag | input | 4 | Request tag |
| resp_valid | output | 1 | Load completes this cycle |
| resp_tag | output | 4 | Tag of the completing load |
| resp_class | output | 2 | Latency class: 0 fast, 1 normal, 2 replay |

## Verification
The hardest state to reach from the ports is a set history bit that meets a qualifying load. That load must be forced to the normal path and must then clear the bit. Non-qualifying loads placed in between must leave the bit alone. The stimulus gets there by sweeping every combination of page offset, displacement, base origin and index kind in one long run, so many crossing loads are followed by every kind of load. A reference history kept in the bench predicts each class. A dedicated chain of loads that always cross pages then confirms the 10/5 alternation. Short hand-built sequences cover ready staying low during a replay and the refusal that avoids two responses landing in the same cycle.

// File: rtl/ldfp_pkg.sv
package ldfp_pkg;
  typedef enum logic [1:0] {
    LAT_FAST   = 2'd0,
    LAT_NORMAL = 2'd1,
    LAT_REPLAY = 2'd2
  } lat_class_e;
endpackage

// File: rtl/ldfp_qualify.sv
// Eligibility test for base-page speculation.
module ldfp_qualify #(
  parameter int DISP_W   = 16,
  parameter int MAX_DISP = 2047
) (
  input  logic signed [DISP_W-1:0] disp,
  input  logic                     base_from_load,
  input  logic                     idx_valid,
  input  logic                     idx_zero,
  output logic                     qualifies
);
  localparam logic signed [DISP_W-1:0] DISP_HI = DISP_W'(MAX_DISP);

  logic disp_ok;
  logic idx_ok;

  always_comb begin
    disp_ok   = (disp >= 0) && (disp <= DISP_HI);
    idx_ok    = !idx_valid || idx_zero;
    qualifies = disp_ok && idx_ok && base_from_load;
  end
endmodule

// File: rtl/ldfp_pagecheck.sv
// Effective address sum and page comparison against the base page.
module ldfp_pagecheck #(
  parameter int ADDR_W    = 64,
  parameter int DISP_W    = 16,
  parameter int PAGE_BITS = 12
) (
  input  logic        [ADDR_W-1:0] base,
  input  logic signed [DISP_W-1:0] disp,
  output logic        [ADDR_W-1:0] eff_addr,
  output logic                     crosses
);
  logic [ADDR_W-1:0] disp_ext;

  always_comb begin
    disp_ext = ADDR_W'(disp);
    eff_addr = base + disp_ext;
    crosses  = base[ADDR_W-1:PAGE_BITS] != eff_addr[ADDR_W-1:PAGE_BITS];
  end
endmodule

// File: rtl/ldfp_sched.sv
// Completion-slot shift line: slot i holds a load that responds i+1 edges later.
module ldfp_sched #(
  parameter int DEPTH = 11,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [1:0]       wr_class,
  output logic [DEPTH-1:0] occ,
  output logic             resp_valid,
  output logic [TAG_W-1:0] resp_tag,
  output logic [1:0]       resp_class
);
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [1:0]       cls_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic             nxt_v;
    logic [TAG_W-1:0] nxt_t;
    logic [1:0]       nxt_c;

    always_comb begin
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        nxt_v = 1'b1;
        nxt_t = wr_tag;
        nxt_c = wr_class;
      end else if (i + 1 < DEPTH) begin
        nxt_v = occ[(i+1) % DEPTH];
        nxt_t = tag_q[(i+1) % DEPTH];
        nxt_c = cls_q[(i+1) % DEPTH];
      end else begin
        nxt_v = 1'b0;
        nxt_t = '0;
        nxt_c = '0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ[i]   <= 1'b0;
        tag_q[i] <= '0;
        cls_q[i] <= '0;
      end else begin
        occ[i]   <= nxt_v;
        tag_q[i] <= nxt_t;
        cls_q[i] <= nxt_c;
      end
    end
  end

  assign resp_valid = occ[0];
  assign resp_tag   = tag_q[0];
  assign resp_class = cls_q[0];

  // R8: a new entry never lands on a slot that an older load shifts into
  p_no_clobber_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_idx) + 1 < DEPTH)) |-> !occ[(int'(wr_idx) + 1) % DEPTH]);

  // R10: a response never carries an undefined class code
  p_class_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_class != 2'd3));
endmodule

// File: rtl/ldfp_stage.sv
module ldfp_stage
  import ldfp_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int DISP_W     = 16,
  parameter int TAG_W      = 4,
  parameter int PAGE_BITS  = 12,
  parameter int MAX_DISP   = 2047,
  parameter int FAST_LAT   = 4,
  parameter int NORMAL_LAT = 5,
  parameter int REPLAY_LAT = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_base,
  input  logic                     req_idx_valid,
  input  logic                     req_idx_zero,
  input  logic signed [DISP_W-1:0] req_disp,
  input  logic                     req_base_from_load,
  input  logic [TAG_W-1:0]         req_tag,
  output logic                     resp_valid,
  output logic [TAG_W-1:0]         resp_tag,
  output logic [1:0]               resp_class
);
  localparam int DEPTH = REPLAY_LAT + 1;
  localparam int IDX_W = $clog2(DEPTH);

  logic              qual;
  logic              crosses;
  logic [ADDR_W-1:0] eff_addr;
  logic              hist_q;
  logic              replay_busy_q;
  lat_class_e        cls;
  logic [IDX_W-1:0]  lat;
  logic [DEPTH-1:0]  occ;
  logic              slot_taken;
  logic              accept;

  ldfp_qualify #(.DISP_W(DISP_W), .MAX_DISP(MAX_DISP)) u_qual (
    .disp           (req_disp),
    .base_from_load (req_base_from_load),
    .idx_valid      (req_idx_valid),
    .idx_zero       (req_idx_zero),
    .qualifies      (qual)
  );

  ldfp_pagecheck #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .PAGE_BITS(PAGE_BITS)) u_page (
    .base     (req_base),
    .disp     (req_disp),
    .eff_addr (eff_addr),
    .crosses  (crosses)
  );

  always_comb begin
    if (!qual || hist_q)  cls = LAT_NORMAL;
    else if (crosses)     cls = LAT_REPLAY;
    else                  cls = LAT_FAST;
    unique case (cls)
      LAT_FAST:   lat = IDX_W'(FAST_LAT);
      LAT_REPLAY: lat = IDX_W'(REPLAY_LAT);
      default:    lat = IDX_W'(NORMAL_LAT);
    endcase
    slot_taken = occ[int'(lat) % DEPTH] && (int'(lat) < DEPTH);
    req_ready  = !replay_busy_q && !slot_taken;
    accept     = req_valid && req_ready;
  end

  ldfp_sched #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (accept),
    .wr_idx     (lat - IDX_W'(1)),
    .wr_tag     (req_tag),
    .wr_class   (cls),
    .occ        (occ),
    .resp_valid (resp_valid),
    .resp_tag   (resp_tag),
    .resp_class (resp_class)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q        <= 1'b0;
      replay_busy_q <= 1'b0;
    end else begin
      if (accept && qual) hist_q <= !hist_q && crosses;
      if (accept && cls == LAT_REPLAY)
        replay_busy_q <= 1'b1;
      else if (resp_valid && resp_class == LAT_REPLAY)
        replay_busy_q <= 1'b0;
    end
  end

  // R7: nothing is taken while a replay is outstanding
  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    replay_busy_q |-> !req_ready);

  // R6: a qualifying load meeting a set history goes normal and clears it
  p_suppress_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && qual && hist_q) |-> (cls == LAT_NORMAL));
  p_hist_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && qual && hist_q) |=> !hist_q);

  // R5: a failed page guess always replays and arms the history
  p_cross_replays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && qual && !hist_q && crosses) |=> (hist_q && replay_busy_q));

  // R1: a non-qualifying load never changes the history
  p_inelig_keeps_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !qual) |=> $stable(hist_q));
endmodule

// File: tb/tb_ldfp_stage.sv
module tb_ldfp_stage;
  localparam int CLK_PERIOD = 10;
  localparam int REPLAY     = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_base;
  logic        req_idx_valid;
  logic        req_idx_zero;
  logic signed [15:0] req_disp;
  logic        req_base_from_load;
  logic [3:0]  req_tag;
  logic        resp_valid;
  logic [3:0]  resp_tag;
  logic [1:0]  resp_class;

  int total = 0;
  int bad   = 0;
  bit hist_m = 1'b0;
  logic [3:0] tag_ctr = 4'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldfp_stage dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_idx_valid(req_idx_valid), .req_idx_zero(req_idx_zero),
    .req_disp(req_disp), .req_base_from_load(req_base_from_load), .req_tag(req_tag),
    .resp_valid(resp_valid), .resp_tag(resp_tag), .resp_class(resp_class)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] b, input bit iv, input bit iz,
                       input int d, input bit fl, input logic [3:0] tg);
    req_valid = 1'b1; req_base = b; req_idx_valid = iv; req_idx_zero = iz;
    req_disp = 16'(d); req_base_from_load = fl; req_tag = tg;
  endtask

  // one load, waits for its response; checks class, latency and tag
  task automatic do_load(input logic [63:0] b, input bit iv, input bit iz,
                         input int d, input bit fl, output int lat);
    bit q, cr;
    int ecls, elat;
    string rq;
    logic [3:0] tg;
    q  = fl && d >= 0 && d <= 2047 && (!iv || iz);
    cr = (b >> 12) != ((b + 64'(d)) >> 12);
    if (!q) begin
      ecls = 1; elat = 5;
      rq = (d < 0 || d > 2047) ? "R1" : (!fl ? "R2" : "R3");
    end else if (hist_m) begin
      ecls = 1; elat = 5; rq = "R6"; hist_m = 1'b0;
    end else if (cr) begin
      ecls = 2; elat = REPLAY; rq = "R5"; hist_m = 1'b1;
    end else begin
      ecls = 0; elat = 4; rq = "R4";
    end
    tg = tag_ctr; tag_ctr = tag_ctr + 4'd1;
    @(negedge clk);
    drive(b, iv, iz, d, fl, tg);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid && lat < 20) begin @(negedge clk); lat++; end
    check(int'(resp_class) == ecls, rq, int'(resp_class), ecls);
    check(lat == elat, rq, lat, elat);
    check(resp_tag == tg, "R10", int'(resp_tag), int'(tg));
  endtask

  function automatic int disp_of(input int k);
    case (k)
      0: return 0;
      1: return 1;
      2: return 100;
      3: return 2047;
      4: return 2048;
      default: return -1;
    endcase
  endfunction

  function automatic logic [63:0] off_of(input int k);
    case (k)
      0: return 64'h000;
      1: return 64'h7FF;
      2: return 64'h800;
      3: return 64'hF80;
      default: return 64'hFFF;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat, sum, refused;
    rst_n = 1'b0; req_valid = 1'b0; req_base = '0; req_idx_valid = 1'b0;
    req_idx_zero = 1'b0; req_disp = '0; req_base_from_load = 1'b0; req_tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(req_ready == 1'b1, "R9 ready", int'(req_ready), 1);
    check(resp_valid == 1'b0, "R9 resp", int'(resp_valid), 0);

    // R8: normal accepted, fast next cycle would collide and must wait one cycle
    drive(64'h1000, 0, 0, 8, 0, 4'hA);
    @(posedge clk);
    @(negedge clk);
    drive(64'h2000, 0, 0, 8, 1, 4'hB);
    #1;
    check(req_ready == 1'b0, "R8 refuse", int'(req_ready), 0);
    @(negedge clk); #1;
    check(req_ready == 1'b1, "R8 retry", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(resp_valid && resp_tag == 4'hA && resp_class == 2'd1, "R8 first", int'(resp_tag), 10);
    @(negedge clk);
    check(resp_valid && resp_tag == 4'hB && resp_class == 2'd0, "R8 second", int'(resp_tag), 11);
    @(negedge clk);

    // R7: replay holds ready low through its response cycle
    drive(64'h3F80, 0, 0, 256, 1, 4'hC);
    @(posedge clk);
    hist_m = 1'b1;
    @(negedge clk);
    drive(64'h5000, 0, 0, 8, 0, 4'hD);
    refused = 0;
    #1;
    while (!req_ready && refused < 30) begin refused++; @(negedge clk); #1; end
    check(refused == REPLAY, "R7 refused cycles", refused, REPLAY);
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    repeat (5) @(negedge clk);

    // exhaustive sweep; history carried across the whole run
    for (int o = 0; o < 5; o++)
      for (int d = 0; d < 6; d++)
        for (int f = 0; f < 2; f++)
          for (int m = 0; m < 3; m++)
            do_load(64'h0000_1234_5000 + off_of(o), m != 0, m == 1,
                    disp_of(d), f == 1, lat);

    // clear the history with a non-crossing qualifying load
    do_load(64'h9000, 0, 0, 16, 1, lat);
    // R6: non-qualifying loads between failure and next qualifier keep history
    do_load(64'h9F00, 0, 0, 512, 1, lat);
    do_load(64'h9F00, 0, 0, 512, 0, lat);
    do_load(64'h9F00, 1, 0, 512, 1, lat);
    do_load(64'hA000, 0, 0, 8, 1, lat);
    check(lat == 5, "R6 deferred suppression", lat, 5);

    // R6: always-crossing chain alternates, averaging 7.5
    do_load(64'hB000, 0, 0, 16, 1, lat);
    sum = 0;
    for (int i = 0; i < 8; i++) begin
      do_load(64'hC000 + 64'(i) * 64'h1000 + 64'hFF0, 0, 0, 32, 1, lat);
      sum += lat;
    end
    check(sum * 2 == 15 * 8, "R6 chain average x2", sum * 2, 120);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule